// File: doc/BRIEF.md
# Sprite Zone and Survival Tracker

This block follows the square player sprite of a lane-crossing game through the field. It tracks whether the sprite stands on safe grass, on the road, or on the river. It decides whether the sprite dies, reaches the goal row, or keeps going. The pixel pipeline sends it a set of colour-class summary flags for the pixels under the sprite, plus the sprite's row index. These flags are sampled once per frame on a strobe raised at the end of the visible area.

The machine has five states: grass, road, river, dead and win. Its outputs depend on both the current state and the present inputs. A dead or win state is held for a fixed number of seconds, measured by a counter scaled by the clock frequency. When the hold expires, the machine pulses a respawn request on the next frame strobe and returns to grass. On a win, that strobe also carries a win pulse.

Top module: `frog_zone_fsm`

## Requirements
- R1: While `rst_n` is low, the machine enters grass. On the first cycle after reset, `dead_o`, `respawn_o`, `win_o` and `on_log_o` are all 0.
- R2: The state changes only on a clock edge where `frame_tick` is 1. Colour flags presented without the strobe have no effect.
- R3: From grass, a strobe with `bg_all_black` enters road, and a strobe with `bg_all_blue` enters river.
- R4: On road, a strobe with `obj_any_nonblack` (a car) enters dead.
- R5: On river, `on_log_o` is 1 while `obj_any_brown` is 1, and the sprite stays alive. A strobe with `obj_all_black` and no brown pixel enters dead.
- R6: A strobe with `bg_all_green` on road (with no car) or on river (with no log) returns to grass, and `dead_o` stays 0.
- R7: From grass, road or river, a strobe with `obj_any_green` and `row_idx` equal to 0 enters win. This check takes priority over every other rule.
- R8: In dead, `dead_o` is 1 until CLK_HZ*HOLD_SEC clock cycles have passed since entry. Before that, a strobe leaves the state unchanged and `respawn_o` stays 0. After it, `respawn_o` is 1 during the strobe and the machine returns to grass.
- R9: In win, `dead_o` is 0. After the hold, the strobe raises `win_o` and `respawn_o` together, and the machine returns to grass.
- R10: In grass, car pixels and all-black object pixels do not kill the sprite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe at end of visible area |
| bg_all_green | input | 1 | Every background pixel under sprite is green |
| bg_all_black | input | 1 | Every background pixel under sprite is black |
| bg_all_blue | input | 1 | Every background pixel under sprite is blue |
| obj_any_nonblack | input | 1 | Some object pixel under sprite is not black |
| obj_all_black | input | 1 | Every object pixel under sprite is black |
| obj_any_brown | input | 1 | Some object pixel under sprite is brown |
| obj_any_green | input | 1 | Some object pixel under sprite is green |
| row_idx | input | ROW_W | Sprite row index, 0 is the goal row |
| dead_o | output | 1 | Sprite is dead and holding |
| respawn_o | output | 1 | Return sprite to start position |
| win_o | output | 1 | Goal reached, pulsed with respawn |
| on_log_o | output | 1 | Sprite rides a log on the river |

## Verification
The bench probes the hold window from both sides. A design that counts from the wrong point or ignores the strobe would respawn early or never. A strobe just after entry must leave `dead_o` high with no respawn. A design that checks for a car before checking for the goal would kill a sprite that reached row 0. A river rule that checks submersion before checking for a log would drown a sprite riding a log. On grass, car and empty-water flags are presented to catch a design that applies hazard rules outside their zone. Flags held without a strobe catch a machine that moves on every clock.

// File: rtl/frog_zone_pkg.sv
// Shared types for the sprite zone tracker.
package frog_zone_pkg;
    typedef enum logic [2:0] {
        ZN_GRASS = 3'd0,
        ZN_ROAD  = 3'd1,
        ZN_RIVER = 3'd2,
        ZN_DEAD  = 3'd3,
        ZN_WIN   = 3'd4
    } zone_e;

    typedef struct packed {
        logic bg_green;
        logic bg_black;
        logic bg_blue;
        logic ob_nonblack;
        logic ob_allblack;
        logic ob_brown;
        logic ob_green;
        logic at_goal;
    } pix_class_t;
endpackage

// File: rtl/frog_hold_timer.sv
// Hold timer: counts clock cycles while run is high and saturates at LIMIT.
// A clear restarts the count at zero. Assumes LIMIT >= 1.
module frog_hold_timer #(
    parameter int unsigned LIMIT = 75_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Counter register: clear wins, otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (clear)               cnt_q <= '0;
        else if (run && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LIM);
endmodule

// File: rtl/frog_zone_next.sv
// Next-state rules for the zone tracker. Purely combinational.
// Assumes the colour flags describe the pixels under the sprite this frame.
module frog_zone_next
    import frog_zone_pkg::*;
(
    input  zone_e      cur,
    input  pix_class_t pc,
    input  logic       hold_done,
    output zone_e      nxt
);
    // Decide the following zone; the goal check outranks every hazard.
    always_comb begin
        nxt = cur;
        unique case (cur)
            ZN_GRASS: begin
                if (pc.ob_green && pc.at_goal) nxt = ZN_WIN;
                else if (pc.bg_black)          nxt = ZN_ROAD;
                else if (pc.bg_blue)           nxt = ZN_RIVER;
            end
            ZN_ROAD: begin
                if (pc.ob_green && pc.at_goal) nxt = ZN_WIN;
                else if (pc.ob_nonblack)       nxt = ZN_DEAD;
                else if (pc.bg_green)          nxt = ZN_GRASS;
            end
            ZN_RIVER: begin
                if (pc.ob_green && pc.at_goal) nxt = ZN_WIN;
                else if (pc.ob_brown)          nxt = ZN_RIVER;
                else if (pc.bg_green)          nxt = ZN_GRASS;
                else if (pc.ob_allblack)       nxt = ZN_DEAD;
            end
            ZN_DEAD, ZN_WIN: begin
                if (hold_done)                 nxt = ZN_GRASS;
            end
            default:                           nxt = ZN_GRASS;
        endcase
    end
endmodule

// File: rtl/frog_zone_fsm.sv
// Sprite zone tracker top. State moves only on frame_tick; dead and win
// hold for CLK_HZ*HOLD_SEC cycles, then pulse respawn on the next strobe.
// Outputs are Mealy: they combine the state with the present inputs.
module frog_zone_fsm
    import frog_zone_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 25_000_000,
    parameter int unsigned HOLD_SEC = 3,
    parameter int unsigned ROW_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic             bg_all_green,
    input  logic             bg_all_black,
    input  logic             bg_all_blue,
    input  logic             obj_any_nonblack,
    input  logic             obj_all_black,
    input  logic             obj_any_brown,
    input  logic             obj_any_green,
    input  logic [ROW_W-1:0] row_idx,
    output logic             dead_o,
    output logic             respawn_o,
    output logic             win_o,
    output logic             on_log_o
);
    localparam int unsigned HOLD_CYC = CLK_HZ * HOLD_SEC;

    zone_e      state_q, state_d;
    pix_class_t pc;
    logic       hold_done, holding, leave;

    assign pc = '{bg_green: bg_all_green, bg_black: bg_all_black,
                  bg_blue: bg_all_blue, ob_nonblack: obj_any_nonblack,
                  ob_allblack: obj_all_black, ob_brown: obj_any_brown,
                  ob_green: obj_any_green, at_goal: (row_idx == '0)};

    frog_zone_next u_next (
        .cur(state_q), .pc(pc), .hold_done(hold_done), .nxt(state_d)
    );

    assign holding = (state_q == ZN_DEAD) || (state_q == ZN_WIN);
    assign leave   = frame_tick && (state_d != state_q);

    frog_hold_timer #(.LIMIT(HOLD_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(leave), .run(holding), .done(hold_done)
    );

    // State register: advance once per frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          state_q <= ZN_GRASS;
        else if (frame_tick) state_q <= state_d;
    end

    // Mealy outputs from state, timer and live inputs.
    always_comb begin
        dead_o    = (state_q == ZN_DEAD) && !hold_done;
        respawn_o = holding && hold_done && frame_tick;
        win_o     = (state_q == ZN_WIN) && hold_done && frame_tick;
        on_log_o  = (state_q == ZN_RIVER) && obj_any_brown;
    end
endmodule

// File: rtl/frog_zone_checker.sv
// Property checker for the zone tracker, bound into every instance.
module frog_zone_checker
    import frog_zone_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  frame_tick,
    input zone_e state_q,
    input logic  dead_o,
    input logic  respawn_o,
    input logic  win_o,
    input logic  on_log_o
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!dead_o && !on_log_o && state_q == ZN_GRASS));

    p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> $stable(state_q));

    p_log_not_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(dead_o && on_log_o));

    p_respawn_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        respawn_o |-> frame_tick);

    p_respawn_to_grass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        respawn_o |=> state_q == ZN_GRASS);

    p_win_with_respawn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_o |-> (respawn_o && !dead_o));
endmodule

bind frog_zone_fsm frog_zone_checker u_chk (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .state_q(state_q),
    .dead_o(dead_o), .respawn_o(respawn_o), .win_o(win_o), .on_log_o(on_log_o)
);

// File: tb/frog_zone_fsm_test.sv
module frog_zone_fsm_test;
    localparam int CLK_PERIOD = 10;
    localparam int HZ   = 10;
    localparam int SEC  = 3;
    localparam int HOLD = HZ * SEC;

    logic clk = 0, rst_n = 0, tick = 0;
    logic g = 0, bk = 0, bl = 0, car = 0, oblk = 0, brn = 0, ogr = 0;
    logic [3:0] row = 4'd7;
    logic dead, resp, win, log_o;
    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frog_zone_fsm #(.CLK_HZ(HZ), .HOLD_SEC(SEC), .ROW_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .frame_tick(tick),
        .bg_all_green(g), .bg_all_black(bk), .bg_all_blue(bl),
        .obj_any_nonblack(car), .obj_all_black(oblk), .obj_any_brown(brn),
        .obj_any_green(ogr), .row_idx(row),
        .dead_o(dead), .respawn_o(resp), .win_o(win), .on_log_o(log_o)
    );

    task automatic chk(string req, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic flags(logic fg, logic fbk, logic fbl, logic fcar,
                         logic fob, logic fbr, logic fgr, logic [3:0] r);
        @(negedge clk);
        g = fg; bk = fbk; bl = fbl; car = fcar; oblk = fob; brn = fbr;
        ogr = fgr; row = r;
    endtask

    // One strobe cycle; Mealy outputs sampled while the strobe is high.
    task automatic strobe(output logic s_resp, output logic s_win);
        @(negedge clk);
        tick = 1;
        #1;
        s_resp = resp; s_win = win;
        @(negedge clk);
        tick = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        flags(0, 0, 0, 0, 0, 0, 0, 4'd7);
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 dead", dead, 0); chk("R1 respawn", resp, 0);
        chk("R1 win", win, 0);   chk("R1 on_log", log_o, 0);
    endtask

    task automatic t_grass_ignores();
        logic r, w;
        do_reset();
        flags(1, 0, 0, 1, 1, 0, 0, 4'd7);
        strobe(r, w);
        chk("R10 car on grass", dead, 0);
        flags(1, 0, 0, 0, 1, 0, 0, 4'd7);
        strobe(r, w);
        chk("R10 empty water on grass", dead, 0);
    endtask

    task automatic t_road_death();
        logic r, w;
        do_reset();
        flags(0, 1, 0, 0, 1, 0, 0, 4'd7);
        strobe(r, w);                          // R3 enter road
        flags(0, 1, 0, 1, 0, 0, 0, 4'd7);
        repeat (3) @(negedge clk);
        chk("R2 no strobe no death", dead, 0);
        strobe(r, w);
        chk("R4 car kills on road", dead, 1);
        chk("R3 road reached", dead, 1);
        strobe(r, w);
        chk("R8 early strobe no respawn", r, 0);
        chk("R8 still dead", dead, 1);
        repeat (HOLD) @(negedge clk);
        chk("R8 hold done dead low", dead, 0);
        flags(1, 0, 0, 0, 1, 0, 0, 4'd7);
        strobe(r, w);
        chk("R8 respawn pulse", r, 1);
        chk("R8 no win on death", w, 0);
        flags(1, 0, 0, 1, 0, 0, 0, 4'd7);
        strobe(r, w);
        chk("R8 back on grass", dead, 0);
    endtask

    task automatic t_river();
        logic r, w;
        do_reset();
        flags(0, 0, 1, 1, 0, 1, 0, 4'd7);
        strobe(r, w);                          // R3 enter river
        chk("R5 on log", log_o, 1);
        strobe(r, w);
        chk("R5 log keeps alive", dead, 0);
        flags(1, 0, 0, 0, 1, 0, 0, 4'd7);
        strobe(r, w);
        chk("R6 river to grass", dead, 0);
        strobe(r, w);
        chk("R6 grass safe", dead, 0);
        flags(0, 0, 1, 0, 1, 0, 0, 4'd7);
        strobe(r, w);
        chk("R5 not on log", log_o, 0);
        strobe(r, w);
        chk("R5 drown", dead, 1);
    endtask

    task automatic t_road_to_grass();
        logic r, w;
        do_reset();
        flags(0, 1, 0, 0, 1, 0, 0, 4'd7);
        strobe(r, w);
        flags(1, 0, 0, 0, 1, 0, 0, 4'd7);
        strobe(r, w);
        flags(1, 0, 0, 1, 0, 0, 0, 4'd7);
        strobe(r, w);
        chk("R6 road to grass", dead, 0);
    endtask

    task automatic t_win();
        logic r, w;
        do_reset();
        flags(0, 1, 0, 0, 1, 0, 0, 4'd7);
        strobe(r, w);
        flags(0, 1, 0, 1, 0, 0, 1, 4'd0);
        strobe(r, w);
        chk("R7 goal beats car", dead, 0);
        chk("R9 win no dead", dead, 0);
        strobe(r, w);
        chk("R9 early no win", w, 0);
        repeat (HOLD) @(negedge clk);
        strobe(r, w);
        chk("R9 win pulse", w, 1);
        chk("R9 respawn with win", r, 1);
    endtask

    task automatic t_reset_mid();
        logic r, w;
        do_reset();
        flags(0, 1, 0, 0, 1, 0, 0, 4'd7);
        strobe(r, w);
        flags(0, 1, 0, 1, 0, 0, 0, 4'd7);
        strobe(r, w);
        do_reset();
        chk("R1 reset clears dead", dead, 0);
    endtask

    initial begin
        t_reset();
        t_grass_ignores();
        t_road_death();
        t_river();
        t_road_to_grass();
        t_win();
        t_reset_mid();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule